// File: doc/BRIEF.md
# In-Router Stream Processing Unit

This block stands in for one input buffer of a mesh network-on-chip router. Flits carry a 32-bit data word plus an instruction flag and a tail flag, and they enter and leave through valid/ready stream ports. By default every flit passes unchanged through a single-entry register stage, so the block behaves like an ordinary one-flit router buffer.

A message can steer part of its payload through a compute core while it crosses the router. The message does this by carrying an in-band instruction flit that names a router address and a flit count. When such a flit reaches the head of the buffer and its address equals this router's coordinates, it is consumed. The next `count` flits are then routed through the core instead of the buffer. A three-state controller with a flit counter drives the input and output multiplexers. Once the last diverted flit has left the core, pass-through mode resumes. The core fitted here is a signed compare-to-threshold stage.

Top module: `sproc_unit`

## Requirements
- R1: After reset the block is in pass-through mode with `out_valid_o` low and `in_ready_o` high.
- R2: In pass-through mode, flits with the instruction flag clear leave in arrival order with data, instruction flag and tail flag unchanged.
- R3: An instruction flit has `in_instr_i`=1, the router X coordinate in data[21:19], the Y coordinate in data[18:16] and the flit count in data[15:0]. An instruction flit whose coordinates differ from the parameters `ROUTER_X`/`ROUTER_Y` is forwarded unchanged.
- R4: An instruction flit with matching coordinates never appears at the output.
- R5: A matching instruction flit with a nonzero count diverts exactly the next `count` accepted flits through the core. Each diverted flit leaves with data 0 when the word, read as a signed 32-bit value, is below `THRESH` (default 110), and data 1 otherwise. It leaves with the instruction flag 0 and its tail flag kept.
- R6: Flits accepted after the diverted group, including the tail flit, pass through unchanged again.
- R7: Once the last diverted flit has been accepted, `in_ready_o` stays low until that flit leaves the core, even when `out_ready_i` is high.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output flit stays valid and unchanged. No flit is lost or duplicated under any back-pressure pattern.
- R9: A matching instruction flit with count 0 is consumed and diverts no flits.
- R10: A flit is taken or delivered only in a cycle where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Upstream flit valid |
| in_instr_i | input | 1 | Upstream instruction flag |
| in_tail_i | input | 1 | Upstream tail flag |
| in_data_i | input | 32 | Upstream data word |
| in_ready_o | output | 1 | Block can take a flit |
| out_valid_o | output | 1 | Flit valid toward crossbar |
| out_instr_o | output | 1 | Outgoing instruction flag |
| out_tail_o | output | 1 | Outgoing tail flag |
| out_data_o | output | 32 | Outgoing data word |
| out_ready_i | input | 1 | Crossbar can take a flit |

## Verification
Two events can fall in the same cycle. The first is the consumption of a matching instruction flit at the buffer head. The second is the arrival of the first payload flit at the input, and that flit must go to the core rather than slip into the emptied buffer. Back-to-back input with random output stalls provokes this pairing many times. A second pairing is the last core flit leaving while a new flit waits at the input, with output ready held high, and the input must stay blocked for that one cycle. A scoreboard fed by the driver from a requirement-level model judges both cases: any misrouted flit shows up as a wrong data value or a wrong ordering at the output.

// File: rtl/sproc_pkg.sv
package sproc_pkg;
  localparam int DATA_W = 32;
  localparam int CRD_W  = 3;
  localparam int ADDR_W = 2 * CRD_W;
  localparam int CNT_W  = 16;
  localparam int ADDR_LSB = CNT_W;

  typedef struct packed {
    logic              instr;
    logic              tail;
    logic [DATA_W-1:0] data;
  } flit_t;

  typedef enum logic [1:0] {
    ST_RELEASE = 2'd0,
    ST_RESERVE = 2'd1,
    ST_IDLE    = 2'd2
  } sproc_state_e;
endpackage

// File: rtl/sproc_stage.sv
module sproc_stage
  import sproc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  in_valid_i,
  input  flit_t in_flit_i,
  output logic  in_ready_o,
  output logic  out_valid_o,
  output flit_t out_flit_o,
  input  logic  out_ready_i
);
  logic  full_q;
  flit_t flit_q;

  assign in_ready_o  = !full_q || out_ready_i;
  assign out_valid_o = full_q;
  assign out_flit_o  = flit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      flit_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      full_q <= 1'b1;
      flit_q <= in_flit_i;
    end else if (out_ready_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sproc_core.sv
module sproc_core
  import sproc_pkg::*;
#(
  parameter int THRESH = 110
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  in_valid_i,
  input  flit_t in_flit_i,
  output logic  in_ready_o,
  output logic  out_valid_o,
  output flit_t out_flit_o,
  input  logic  out_ready_i
);
  flit_t res;

  always_comb begin
    res       = '0;
    res.tail  = in_flit_i.tail;
    res.data  = ($signed(in_flit_i.data) < $signed(THRESH)) ? '0 : DATA_W'(1);
  end

  sproc_stage u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_flit_i  (res),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o),
    .out_flit_o (out_flit_o),
    .out_ready_i(out_ready_i)
  );
endmodule

// File: rtl/sproc_ctrl.sv
module sproc_ctrl
  import sproc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  output logic               buf_in_valid_o,
  input  logic               buf_in_ready_i,
  output logic               core_in_valid_o,
  input  logic               core_in_ready_i,
  input  logic               buf_out_valid_i,
  input  flit_t              buf_out_flit_i,
  output logic               buf_out_ready_o,
  input  logic               core_out_valid_i,
  input  flit_t              core_out_flit_i,
  output logic               core_out_ready_o,
  output logic               out_valid_o,
  output flit_t              out_flit_o,
  input  logic               out_ready_i,
  output sproc_state_e       state_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   tgt_o
);
  sproc_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, tgt_q, tgt_d;
  logic [CNT_W-1:0] hit_cnt;
  logic             head_hit;

  assign hit_cnt  = buf_out_flit_i.data[CNT_W-1:0];
  assign head_hit = buf_out_valid_i && buf_out_flit_i.instr &&
                    (buf_out_flit_i.data[ADDR_LSB +: ADDR_W] == MY_ADDR);

  always_comb begin
    in_ready_o       = 1'b0;
    buf_in_valid_o   = 1'b0;
    core_in_valid_o  = 1'b0;
    buf_out_ready_o  = 1'b0;
    core_out_ready_o = 1'b0;
    out_valid_o      = 1'b0;
    out_flit_o       = buf_out_flit_i;
    state_d          = state_q;
    cnt_d            = cnt_q;
    tgt_d            = tgt_q;
    unique case (state_q)
      ST_RELEASE: begin
        // a matching instruction at the head is dropped; input waits so the
        // next flit is steered to the core, not into the buffer
        buf_in_valid_o  = in_valid_i && !head_hit;
        in_ready_o      = buf_in_ready_i && !head_hit;
        out_valid_o     = buf_out_valid_i && !head_hit;
        buf_out_ready_o = head_hit || out_ready_i;
        if (head_hit && hit_cnt != '0) begin
          state_d = ST_RESERVE;
          cnt_d   = '0;
          tgt_d   = hit_cnt;
        end
      end
      ST_RESERVE: begin
        core_in_valid_o  = in_valid_i;
        in_ready_o       = core_in_ready_i;
        out_valid_o      = core_out_valid_i;
        out_flit_o       = core_out_flit_i;
        core_out_ready_o = out_ready_i;
        if (in_valid_i && core_in_ready_i) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_d == tgt_q) state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        out_valid_o      = core_out_valid_i;
        out_flit_o       = core_out_flit_i;
        core_out_ready_o = out_ready_i;
        if (!core_out_valid_i || out_ready_i) state_d = ST_RELEASE;
      end
      default: state_d = ST_RELEASE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RELEASE;
      cnt_q   <= '0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tgt_q   <= tgt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign tgt_o   = tgt_q;
endmodule

// File: rtl/sproc_unit.sv
module sproc_unit
  import sproc_pkg::*;
#(
  parameter int ROUTER_X = 3,
  parameter int ROUTER_Y = 5,
  parameter int THRESH   = 110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_instr_i,
  input  logic              in_tail_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic              out_instr_o,
  output logic              out_tail_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  localparam logic [ADDR_W-1:0] MY_ADDR = {CRD_W'(ROUTER_X), CRD_W'(ROUTER_Y)};

  flit_t            in_flit, buf_out_flit, core_out_flit, out_flit;
  logic             buf_in_valid, buf_in_ready, buf_out_valid, buf_out_ready;
  logic             core_in_valid, core_in_ready, core_out_valid, core_out_ready;
  sproc_state_e     state;
  logic [CNT_W-1:0] cnt, tgt;

  assign in_flit = '{instr: in_instr_i, tail: in_tail_i, data: in_data_i};

  sproc_stage u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (buf_in_valid),
    .in_flit_i  (in_flit),
    .in_ready_o (buf_in_ready),
    .out_valid_o(buf_out_valid),
    .out_flit_o (buf_out_flit),
    .out_ready_i(buf_out_ready)
  );

  sproc_core #(.THRESH(THRESH)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (core_in_valid),
    .in_flit_i  (in_flit),
    .in_ready_o (core_in_ready),
    .out_valid_o(core_out_valid),
    .out_flit_o (core_out_flit),
    .out_ready_i(core_out_ready)
  );

  sproc_ctrl #(.MY_ADDR(MY_ADDR)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .in_valid_i      (in_valid_i),
    .in_ready_o      (in_ready_o),
    .buf_in_valid_o  (buf_in_valid),
    .buf_in_ready_i  (buf_in_ready),
    .core_in_valid_o (core_in_valid),
    .core_in_ready_i (core_in_ready),
    .buf_out_valid_i (buf_out_valid),
    .buf_out_flit_i  (buf_out_flit),
    .buf_out_ready_o (buf_out_ready),
    .core_out_valid_i(core_out_valid),
    .core_out_flit_i (core_out_flit),
    .core_out_ready_o(core_out_ready),
    .out_valid_o     (out_valid_o),
    .out_flit_o      (out_flit),
    .out_ready_i     (out_ready_i),
    .state_o         (state),
    .cnt_o           (cnt),
    .tgt_o           (tgt)
  );

  assign out_instr_o = out_flit.instr;
  assign out_tail_o  = out_flit.tail;
  assign out_data_o  = out_flit.data;
endmodule

// File: rtl/sproc_unit_chk.sv
module sproc_unit_chk
  import sproc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_instr_o,
  input logic              out_tail_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ready_i,
  input sproc_state_e      state_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  tgt_i
);
  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_tail_o) && $stable(out_instr_o));

  a_r7_idle_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE |-> !in_ready_o);

  a_r5_core_binary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && state_i != ST_RELEASE |-> out_data_o[DATA_W-1:1] == '0 && !out_instr_o);

  a_r4_hit_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_instr_o |->
      state_i == ST_RELEASE && out_data_o[ADDR_LSB +: ADDR_W] != MY_ADDR);

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_RESERVE |-> cnt_i < tgt_i);

  a_r6_idle_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_i) == ST_IDLE && state_i != ST_IDLE |-> state_i == ST_RELEASE);
endmodule

bind sproc_unit sproc_unit_chk #(.MY_ADDR(MY_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_instr_o(out_instr_o),
  .out_tail_o (out_tail_o),
  .out_data_o (out_data_o),
  .out_ready_i(out_ready_i),
  .state_i    (state),
  .cnt_i      (cnt),
  .tgt_i      (tgt)
);

// File: tb/sim_sproc_unit.sv
`timescale 1ns/1ps
module sim_sproc_unit;
  import sproc_pkg::*;

  localparam int RX = 3;
  localparam int RY = 5;
  localparam int TH = 110;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic              in_instr_i = 1'b0;
  logic              in_tail_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              in_ready_o;
  logic              out_valid_o;
  logic              out_instr_o;
  logic              out_tail_o;
  logic [DATA_W-1:0] out_data_o;
  logic              out_ready_i = 1'b1;

  int    n_run = 0;
  int    n_fail = 0;
  int    ready_mode = 0;   // 0 random, 1 always high
  int    rem = 0;
  flit_t exp_q[$];
  string tag_q[$];

  always #2.5 clk_i = ~clk_i;

  sproc_unit #(.ROUTER_X(RX), .ROUTER_Y(RY), .THRESH(TH)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_instr_i(in_instr_i), .in_tail_i(in_tail_i),
    .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_instr_o(out_instr_o), .out_tail_o(out_tail_o),
    .out_data_o(out_data_o), .out_ready_i(out_ready_i)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic flit_t mk(input bit ins, input bit tl, input logic [31:0] d);
    flit_t f;
    f.instr = ins; f.tail = tl; f.data = d;
    return f;
  endfunction

  function automatic flit_t mk_ins(input int x, input int y, input int cnt);
    return mk(1'b1, 1'b0, {10'd0, 3'(x), 3'(y), 16'(cnt)});
  endfunction

  // requirement-level model, applied at the accepting edge
  task automatic model(input flit_t f, input string req);
    flit_t e;
    if (rem > 0) begin
      e = mk(1'b0, f.tail, ($signed(f.data) < TH) ? 32'd0 : 32'd1);
      exp_q.push_back(e); tag_q.push_back("R5");
      rem--;
    end else if (f.instr && f.data[21:19] == 3'(RX) && f.data[18:16] == 3'(RY)) begin
      rem = int'(f.data[15:0]);
    end else begin
      exp_q.push_back(f); tag_q.push_back(req);
    end
  endtask

  task automatic send(input flit_t f, input string req);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_instr_i = f.instr; in_tail_i = f.tail; in_data_i = f.data;
    forever begin
      #1;
      if (in_ready_o) break;
      @(negedge clk_i);
    end
    model(f, req);
    @(posedge clk_i);
    #1 in_valid_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      out_ready_i = (ready_mode == 1) ? 1'b1 : (($urandom % 4) != 0);
      #1;
      if (rst_ni && out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected flit", {30'd0, out_instr_o, out_tail_o, out_data_o}, 64'd0);
        end else begin
          flit_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_instr_o, out_tail_o, out_data_o} == e, t,
                {30'd0, out_instr_o, out_tail_o, out_data_o}, {30'd0, e});
        end
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(posedge clk_i); guard++;
    end
    repeat (4) @(posedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    check(!out_valid_o, "R1 out_valid", {63'd0, out_valid_o}, 64'd0);
    check(in_ready_o, "R1 in_ready", {63'd0, in_ready_o}, 64'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check(!out_valid_o && in_ready_o, "R1 after release", {62'd0, out_valid_o, in_ready_o}, 64'd1);

    // R2: plain message, no instruction flit
    send(mk(0, 0, 32'h0000_1111), "R2");
    for (int i = 0; i < 5; i++) send(mk(0, 0, 32'hA000_0000 + i), "R2");
    send(mk(0, 1, 32'h0000_00EE), "R2");
    drain();

    // R3: instruction flit for another router forwarded unchanged
    send(mk(0, 0, 32'h0000_2222), "R3");
    send(mk_ins(RX, 2, 3), "R3");
    send(mk_ins(1, RY, 2), "R3");
    for (int i = 0; i < 4; i++) send(mk(0, 0, 32'd50 + 40 * i), "R3");
    send(mk(0, 1, 32'd7), "R3");
    drain();

    // R4 R5 R6: matching instruction, threshold boundaries, then tail passes
    send(mk(0, 0, 32'h0000_3333), "R4");
    send(mk_ins(RX, RY, 6), "R4");
    send(mk(0, 0, 32'd109), "R5");
    send(mk(0, 0, 32'd110), "R5");
    send(mk(0, 0, 32'd111), "R5");
    send(mk(0, 0, 32'hFFFF_FFFF), "R5");
    send(mk(0, 0, 32'h7FFF_FFFF), "R5");
    send(mk(0, 1, 32'd0), "R5");
    send(mk(0, 0, 32'd5), "R6");
    send(mk(0, 1, 32'd500), "R6");
    drain();

    // R9: count zero diverts nothing
    send(mk(0, 0, 32'h0000_4444), "R9");
    send(mk_ins(RX, RY, 0), "R9");
    send(mk(0, 0, 32'd3), "R9");
    send(mk(0, 1, 32'd900), "R9");
    drain();

    // R7: input blocked for one cycle after last diverted flit, ready high
    ready_mode = 1;
    @(negedge clk_i);
    send(mk(0, 0, 32'h0000_5555), "R7");
    send(mk_ins(RX, RY, 1), "R7");
    send(mk(0, 0, 32'd200), "R7");
    @(negedge clk_i);
    #1;
    check(!in_ready_o, "R7 in_ready in idle", {63'd0, in_ready_o}, 64'd0);
    check(out_valid_o && out_data_o == 32'd1, "R7 core flit pending",
          {31'd0, out_valid_o, out_data_o}, {31'd0, 1'b1, 32'd1});
    send(mk(0, 1, 32'd20), "R7");
    drain();
    ready_mode = 0;

    // R8 R10: long randomized traffic under random back-pressure
    for (int m = 0; m < 40; m++) begin
      int nd;
      nd = 1 + ($urandom % 5);
      send(mk(0, 0, 32'h00C0_0000 + m), "R8");
      if (m % 3 == 0) send(mk_ins(RX, RY, nd), "R10");
      else if (m % 3 == 1) send(mk_ins(RX ^ 1, RY, nd), "R10");
      for (int k = 0; k < nd + 2; k++) send(mk(0, 0, $urandom % 256), "R8");
      send(mk(0, 1, $urandom), "R8");
    end
    drain();
    check(exp_q.size() == 0, "R8 all delivered", 64'(exp_q.size()), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule